// File: doc/BRIEF.md
# Coprocessor Operand Transfer Sequencer

This block moves word operands between system memory and an external math coprocessor. A processor-side escape strobe arms it with an operand start address, a direction and a word count. After that, each time the coprocessor raises its request line, the sequencer runs one word transfer. A word transfer is a short list of bus operations: one word access to the coprocessor data port at I/O address 0x00FA, plus one memory word access, or two memory byte accesses when the operand sits at an odd byte address.

Each bus operation is presented on a registered request interface. The interface carries the address, an I/O-or-memory select, a read-or-write select and a byte-or-word select. The operation is held until the bus controller returns a done pulse. Two status bits gate all coprocessor traffic: an emulate bit and a task-switched bit. While either bit is set, escapes do not arm the block and coprocessor requests are dropped. A sticky flag reports a dropped request. The block does not decode instructions, carry data, or model bus timing.

Top module: `cpx_operand_seq`

## Requirements
- R1: After a synchronous reset, bus_req, busy, armed and req_ignored are all 0.
- R2: An esc_go pulse while idle arms the block (armed=1) only when st_emul=0, st_tswitch=0 and esc_words is nonzero. In every other case armed stays at its previous value.
- R3: While armed and idle, with both status bits 0, cop_req=1 starts a word transfer, and bus_req is 1 in the cycle after cop_req is sampled.
- R4: With esc_dir=0 (memory to coprocessor) and an even address A, the transfer is a memory word read at A, then an I/O word write at 0x00FA. Encoding: bus_io=1 means I/O, bus_wr=1 means write, bus_byte=1 means byte.
- R5: With esc_dir=1 (coprocessor to memory) and an even address A, the transfer is an I/O word read at 0x00FA, then a memory word write at A.
- R6: With an odd address A, the memory part becomes two byte operations, at A and then at A+1 (modulo 2^16), giving three operations in total. The order relative to the port access is the same as in R4 and R5, and I/O operations are never byte-sized.
- R7: Each bus operation keeps bus_req and its fields unchanged until bus_done. Each bus_done advances exactly one operation, and bus_req drops after the last one.
- R8: After each completed word, the operand address advances by 2. armed clears when the armed number of words has completed.
- R9: A cop_req while idle and either not armed or with a status bit set starts no bus operation and sets req_ignored. req_ignored clears on the next accepted escape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| esc_go | input | 1 | Escape-with-memory-operand strobe |
| esc_addr | input | AW | Operand start byte address |
| esc_dir | input | 1 | 0: memory to coprocessor, 1: coprocessor to memory |
| esc_words | input | CW | Number of word operands to move |
| st_emul | input | 1 | Emulate status bit, blocks coprocessor access when 1 |
| st_tswitch | input | 1 | Task-switched status bit, blocks coprocessor access when 1 |
| cop_req | input | 1 | Coprocessor operand request (level) |
| bus_done | input | 1 | Current bus operation completed |
| armed | output | 1 | Operand transfers enabled |
| busy | output | 1 | Word transfer in progress |
| req_ignored | output | 1 | Sticky: a request was dropped |
| bus_req | output | 1 | Bus operation request |
| bus_addr | output | AW | Bus operation address |
| bus_io | output | 1 | 1: I/O space, 0: memory |
| bus_wr | output | 1 | 1: write, 0: read |
| bus_byte | output | 1 | 1: byte, 0: word |

## Verification
The bench walks both directions at even and odd addresses, including 0xFFFF, where the second byte wraps to 0x0000 and the next word starts at 0x0001. A sequencer that swapped the port and memory order, or that used a word access at an odd address, would produce a wrong operation list. One that added 1 instead of 2 between words would fail the second word of every vector. A stall on the first operation exposes a design that advances without bus_done. Requests made with no escape, with a status bit set, or after the word count has run out must show no bus_req and a set req_ignored flag. An escape with a zero count or a status bit set must leave armed clear, which catches gating that is inverted or missing.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

  typedef enum logic [1:0] {
    ASEL_BASE = 2'd0,
    ASEL_NEXT = 2'd1,
    ASEL_PORT = 2'd2
  } cpx_asel_e;

  typedef struct packed {
    logic      io;
    logic      wr;
    logic      byt;
    cpx_asel_e asel;
  } cpx_op_t;

endpackage

// File: rtl/cpx_step_plan.sv
module cpx_step_plan
  import cpx_pkg::*;
(
  input  logic       dir,
  input  logic       odd,
  input  logic [1:0] step,
  output cpx_op_t    op,
  output logic       last
);

  always_comb begin
    op   = '{io: 1'b0, wr: 1'b0, byt: 1'b0, asel: ASEL_BASE};
    last = 1'b0;
    case ({dir, odd})
      2'b00: begin
        if (step == 2'd0) op = '{io: 1'b0, wr: 1'b0, byt: 1'b0, asel: ASEL_BASE};
        else begin
          op   = '{io: 1'b1, wr: 1'b1, byt: 1'b0, asel: ASEL_PORT};
          last = 1'b1;
        end
      end
      2'b01: begin
        if (step == 2'd0)      op = '{io: 1'b0, wr: 1'b0, byt: 1'b1, asel: ASEL_BASE};
        else if (step == 2'd1) op = '{io: 1'b0, wr: 1'b0, byt: 1'b1, asel: ASEL_NEXT};
        else begin
          op   = '{io: 1'b1, wr: 1'b1, byt: 1'b0, asel: ASEL_PORT};
          last = 1'b1;
        end
      end
      2'b10: begin
        if (step == 2'd0) op = '{io: 1'b1, wr: 1'b0, byt: 1'b0, asel: ASEL_PORT};
        else begin
          op   = '{io: 1'b0, wr: 1'b1, byt: 1'b0, asel: ASEL_BASE};
          last = 1'b1;
        end
      end
      default: begin
        if (step == 2'd0)      op = '{io: 1'b1, wr: 1'b0, byt: 1'b0, asel: ASEL_PORT};
        else if (step == 2'd1) op = '{io: 1'b0, wr: 1'b1, byt: 1'b1, asel: ASEL_BASE};
        else begin
          op   = '{io: 1'b0, wr: 1'b1, byt: 1'b1, asel: ASEL_NEXT};
          last = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/cpx_gate.sv
module cpx_gate #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          esc_go,
  input  logic [AW-1:0] esc_addr,
  input  logic          esc_dir,
  input  logic [CW-1:0] esc_words,
  input  logic          st_emul,
  input  logic          st_tswitch,
  input  logic          cop_req,
  input  logic          idle,
  input  logic          word_done,
  output logic          start,
  output logic          armed,
  output logic          cur_dir,
  output logic [AW-1:0] cur_addr,
  output logic          req_ignored
);

  logic          open_ok;
  logic          acc_esc;
  logic          rej_req;
  logic [CW-1:0] left_q;

  assign open_ok = ~st_emul & ~st_tswitch;
  assign acc_esc = esc_go & idle & open_ok & (esc_words != '0);
  assign start   = idle & cop_req & ~esc_go & armed & open_ok;
  assign rej_req = idle & cop_req & ~esc_go & ~(armed & open_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      cur_dir     <= 1'b0;
      cur_addr    <= '0;
      left_q      <= '0;
      req_ignored <= 1'b0;
    end else begin
      if (acc_esc) begin
        armed    <= 1'b1;
        cur_dir  <= esc_dir;
        cur_addr <= esc_addr;
        left_q   <= esc_words;
      end else if (word_done) begin
        cur_addr <= cur_addr + AW'(2);
        left_q   <= left_q - CW'(1);
        if (left_q == CW'(1)) armed <= 1'b0;
      end
      if (acc_esc)      req_ignored <= 1'b0;
      else if (rej_req) req_ignored <= 1'b1;
    end
  end

  assert_drop_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (idle && cop_req && !esc_go && !armed) |=> req_ignored);

  assert_gate_esc_R2: assert property (@(posedge clk) disable iff (rst)
    (esc_go && (st_emul || st_tswitch) && !armed) |=> !armed);

  assert_disarm_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(armed) |-> $past(word_done));

  assert_step_two_R8: assert property (@(posedge clk) disable iff (rst)
    (word_done && !esc_go) |=> cur_addr == $past(cur_addr) + AW'(2));

endmodule

// File: rtl/cpx_operand_seq.sv
module cpx_operand_seq
  import cpx_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   CW        = 4,
  parameter logic [AW-1:0] DATA_PORT = AW'('h00FA)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          esc_go,
  input  logic [AW-1:0] esc_addr,
  input  logic          esc_dir,
  input  logic [CW-1:0] esc_words,
  input  logic          st_emul,
  input  logic          st_tswitch,
  input  logic          cop_req,
  input  logic          bus_done,
  output logic          armed,
  output logic          busy,
  output logic          req_ignored,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_io,
  output logic          bus_wr,
  output logic          bus_byte
);

  logic          start;
  logic          cur_dir;
  logic [AW-1:0] cur_addr;
  logic          word_done;
  logic [1:0]    step_q;
  logic [1:0]    sel_step;
  logic          last_q;
  cpx_op_t       plan_op;
  logic          plan_last;
  logic [AW-1:0] plan_addr;

  assign word_done = busy & bus_done & last_q;
  assign sel_step  = busy ? (step_q + 2'd1) : 2'd0;

  cpx_gate #(.AW(AW), .CW(CW)) gate_i (
    .clk         (clk),
    .rst         (rst),
    .esc_go      (esc_go),
    .esc_addr    (esc_addr),
    .esc_dir     (esc_dir),
    .esc_words   (esc_words),
    .st_emul     (st_emul),
    .st_tswitch  (st_tswitch),
    .cop_req     (cop_req),
    .idle        (~busy),
    .word_done   (word_done),
    .start       (start),
    .armed       (armed),
    .cur_dir     (cur_dir),
    .cur_addr    (cur_addr),
    .req_ignored (req_ignored)
  );

  cpx_step_plan plan_i (
    .dir  (cur_dir),
    .odd  (cur_addr[0]),
    .step (sel_step),
    .op   (plan_op),
    .last (plan_last)
  );

  always_comb begin
    case (plan_op.asel)
      ASEL_NEXT: plan_addr = cur_addr + AW'(1);
      ASEL_PORT: plan_addr = DATA_PORT;
      default:   plan_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      step_q   <= 2'd0;
      last_q   <= 1'b0;
      bus_req  <= 1'b0;
      bus_addr <= '0;
      bus_io   <= 1'b0;
      bus_wr   <= 1'b0;
      bus_byte <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        step_q   <= 2'd0;
        last_q   <= plan_last;
        bus_req  <= 1'b1;
        bus_addr <= plan_addr;
        bus_io   <= plan_op.io;
        bus_wr   <= plan_op.wr;
        bus_byte <= plan_op.byt;
      end
    end else if (bus_done) begin
      if (last_q) begin
        busy    <= 1'b0;
        bus_req <= 1'b0;
      end else begin
        step_q   <= sel_step;
        last_q   <= plan_last;
        bus_addr <= plan_addr;
        bus_io   <= plan_op.io;
        bus_wr   <= plan_op.wr;
        bus_byte <= plan_op.byt;
      end
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_io)
                                && $stable(bus_wr) && $stable(bus_byte)));

  assert_port_word_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_io) |-> (bus_addr == DATA_PORT && !bus_byte));

  assert_start_gate_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> ($past(cop_req) && $past(armed) && !$past(st_emul) && !$past(st_tswitch)));

  assert_no_req_idle_R7: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

endmodule

// File: tb/cpx_operand_seq_tb.sv
`timescale 1ns/1ps
module cpx_operand_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        esc_go = 1'b0;
  logic [15:0] esc_addr = '0;
  logic        esc_dir = 1'b0;
  logic [3:0]  esc_words = '0;
  logic        st_emul = 1'b0;
  logic        st_tswitch = 1'b0;
  logic        cop_req = 1'b0;
  logic        bus_done = 1'b0;
  logic        armed, busy, req_ignored, bus_req, bus_io, bus_wr, bus_byte;
  logic [15:0] bus_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cpx_operand_seq dut_i (
    .clk(clk), .rst(rst), .esc_go(esc_go), .esc_addr(esc_addr), .esc_dir(esc_dir),
    .esc_words(esc_words), .st_emul(st_emul), .st_tswitch(st_tswitch), .cop_req(cop_req),
    .bus_done(bus_done), .armed(armed), .busy(busy), .req_ignored(req_ignored),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_io(bus_io), .bus_wr(bus_wr), .bus_byte(bus_byte)
  );

  // {direction, start address}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 16'h1000}, {1'b1, 16'h2000}, {1'b0, 16'h3001},
    {1'b1, 16'h4003}, {1'b0, 16'hFFFF}, {1'b1, 16'h00FA}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {io, wr, byte, addr}
  function automatic logic [18:0] exp_op(input logic d, input logic [15:0] a, input int k);
    logic [15:0] nx;
    nx = a + 16'd1;
    if (!d) begin
      if (!a[0]) return (k == 0) ? {3'b000, a} : {3'b110, 16'h00FA};
      if (k == 0) return {3'b001, a};
      if (k == 1) return {3'b001, nx};
      return {3'b110, 16'h00FA};
    end
    if (!a[0]) return (k == 0) ? {3'b100, 16'h00FA} : {3'b010, a};
    if (k == 0) return {3'b100, 16'h00FA};
    if (k == 1) return {3'b011, a};
    return {3'b011, nx};
  endfunction

  task automatic escape(input logic d, input logic [15:0] a, input logic [3:0] w);
    @(negedge clk);
    esc_go = 1'b1; esc_dir = d; esc_addr = a; esc_words = w;
    @(negedge clk);
    esc_go = 1'b0;
  endtask

  task automatic do_word(input logic d, input logic [15:0] a, input int stall);
    logic [18:0] obs;
    logic [18:0] held;
    string tag;
    int n_ops;
    n_ops = a[0] ? 3 : 2;
    tag = a[0] ? "R6" : (d ? "R5" : "R4");
    @(negedge clk); cop_req = 1'b1;
    @(negedge clk); cop_req = 1'b0;
    chk(bus_req === 1'b1, "R3 start", {31'd0, bus_req}, 32'd1);
    for (int k = 0; k < n_ops; k++) begin
      obs = {bus_io, bus_wr, bus_byte, bus_addr};
      if (k == 0 && stall > 0) begin
        held = obs;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          obs = {bus_io, bus_wr, bus_byte, bus_addr};
          chk(bus_req === 1'b1 && obs === held, "R7 hold", {13'd0, obs}, {13'd0, held});
        end
      end
      chk(bus_req === 1'b1 && obs === exp_op(d, a, k), tag, {13'd0, obs}, {13'd0, exp_op(d, a, k)});
      bus_done = 1'b1;
      @(negedge clk);
    end
    bus_done = 1'b0;
    chk(bus_req === 1'b0, "R7 end", {31'd0, bus_req}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({bus_req, busy, armed, req_ignored} === 4'b0, "R1",
        {28'd0, bus_req, busy, armed, req_ignored}, 32'd0);

    // R9: request without any escape
    @(negedge clk); cop_req = 1'b1;
    @(negedge clk); cop_req = 1'b0;
    chk(bus_req === 1'b0 && req_ignored === 1'b1, "R9 unarmed",
        {30'd0, bus_req, req_ignored}, 32'd1);

    // R2: status bits block arming
    st_emul = 1'b1;
    escape(1'b0, 16'h0100, 4'd1);
    chk(armed === 1'b0, "R2 emul", {31'd0, armed}, 32'd0);
    st_emul = 1'b0; st_tswitch = 1'b1;
    escape(1'b0, 16'h0100, 4'd1);
    chk(armed === 1'b0, "R2 tswitch", {31'd0, armed}, 32'd0);
    st_tswitch = 1'b0;
    escape(1'b0, 16'h0100, 4'd0);
    chk(armed === 1'b0, "R2 zero count", {31'd0, armed}, 32'd0);

    // vector walk: two words each
    for (int v = 0; v < 6; v++) begin
      escape(VEC[v][16], VEC[v][15:0], 4'd2);
      chk(armed === 1'b1 && req_ignored === 1'b0, "R2 arm / R9 clear",
          {30'd0, armed, req_ignored}, 32'd2);
      do_word(VEC[v][16], VEC[v][15:0], (v == 0) ? 3 : 0);
      chk(armed === 1'b1, "R8 still armed", {31'd0, armed}, 32'd1);
      do_word(VEC[v][16], VEC[v][15:0] + 16'd2, 0);
      chk(armed === 1'b0, "R8 disarm", {31'd0, armed}, 32'd0);
    end

    // R8: count exhausted, further request dropped
    @(negedge clk); cop_req = 1'b1;
    @(negedge clk); cop_req = 1'b0;
    chk(bus_req === 1'b0 && req_ignored === 1'b1, "R8 R9 after count",
        {30'd0, bus_req, req_ignored}, 32'd1);

    // R9: armed but task-switched bit set
    escape(1'b1, 16'h0500, 4'd1);
    st_tswitch = 1'b1;
    @(negedge clk); cop_req = 1'b1;
    @(negedge clk); cop_req = 1'b0;
    @(negedge clk);
    chk(bus_req === 1'b0 && req_ignored === 1'b1 && armed === 1'b1, "R9 blocked",
        {29'd0, bus_req, req_ignored, armed}, 32'd3);
    st_tswitch = 1'b0;
    do_word(1'b1, 16'h0500, 0);
    chk(armed === 1'b0, "R8 single word", {31'd0, armed}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule